// File: doc/BRIEF.md
# Multimode Test Register

This block is a register of parameterised width that takes one of four jobs under a two-bit mode code. In everyday operation it is a plain parallel-load register between two pieces of logic. For test it can be turned into a scan chain that moves data from a serial input to a serial output. It can be cleared in a single clock. It can also be turned into a multiple-input signature register that folds a stream of parallel response words into one compact signature.

If the parallel inputs are held at zero while the register is in signature mode, it runs as a maximal-length linear feedback shift register. In that use it acts as a pseudorandom pattern source for the logic it feeds. The feedback taps are a parameter. The default taps give the primitive characteristic polynomial 1 + x + x^4 for a width of four. The width must be at least two.

Top module: `mmtr_reg`

## Requirements
- R1: While `rst` is high, the next clock edge sets every stage to 0. As a result `state_q` is 0 and `ser_out` is 0.
- R2: When `mode_sel` is 2'b00 (shift), stage 0 takes `ser_in` and each stage k>0 takes the old value of stage k-1 on every clock.
- R3: When `mode_sel` is 2'b01 (clear), every stage becomes 0 on the next clock, whatever `par_in` and `ser_in` hold.
- R4: When `mode_sel` is 2'b11 (load), `state_q` takes `par_in` bit for bit on the next clock, and `ser_in` has no effect.
- R5: When `mode_sel` is 2'b10 (signature), stage 0 takes fb XOR `par_in[0]`. Each stage k>0 takes old stage k-1 XOR `par_in[k]`. Here fb is the XOR of the old stages whose bit is set in `FB_TAPS`. The default `FB_TAPS` = 4'b1001 means fb = stage 3 XOR stage 0.
- R6: `ser_out` always equals the last stage, `state_q[W-1]`.
- R7: With the default taps, `par_in` held at 0 and a nonzero seed, signature mode visits 2^W-1 distinct nonzero states. It returns to the seed only after exactly 2^W-1 clocks.
- R8: During a compaction of several words, flipping one bit of `par_in` in one cycle gives a final signature different from the fault-free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode code: 00 shift, 01 clear, 10 signature, 11 load |
| par_in | input | W | Parallel data / response word |
| ser_in | input | 1 | Serial data into stage 0 in shift mode |
| state_q | output | W | Register contents |
| ser_out | output | 1 | Last stage, serial output |

## Verification
The bench goes after the behaviour at the edges of the shift chain and the feedback path.

- A stage-0 multiplexer that picks the wrong source would push feedback into the scan chain, or serial data into the signature. Both show up as a wrong next state.
- A misplaced tap would shorten the cycle of the pseudorandom sequence. The full-period walk catches this as a repeated state or an early return to the seed.
- A missing XOR on one parallel input would make a flipped response bit invisible, and the faulty signature would equal the fault-free one.
- The bench also sweeps every load value and every signature seed against an arithmetic model.

// File: rtl/mmtr_pkg.sv
package mmtr_pkg;

    // Mode code: bit 1 is the first mode bit, bit 0 the second.
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIGN  = 2'b10,
        MODE_LOAD  = 2'b11
    } mmtr_mode_e;

    // Inputs seen by one storage cell.
    typedef struct packed {
        logic link;   // previous stage, or head mux for stage 0
        logic par;    // parallel input bit
    } cell_in_t;

    // Next-state function of one cell.
    function automatic logic cell_next(mmtr_mode_e m, cell_in_t ci);
        logic r;
        unique case (m)
            MODE_SHIFT: r = ci.link;
            MODE_CLEAR: r = 1'b0;
            MODE_SIGN:  r = ci.link ^ ci.par;
            default:    r = ci.par;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mmtr_feedback.sv
module mmtr_feedback #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   TAPS = 'b1001
) (
    input  logic [W-1:0] state,
    output logic         fb
);
    logic [W-1:0] tapped;

    // Per-stage tap gating; bits without a tap drop out of the XOR.
    for (genvar k = 0; k < W; k++) begin : g_tap
        if (TAPS[k]) begin : g_on
            assign tapped[k] = state[k];
        end else begin : g_off
            assign tapped[k] = 1'b0;
        end
    end

    assign fb = ^tapped;
endmodule

// File: rtl/mmtr_stage.sv
module mmtr_stage
    import mmtr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mmtr_mode_e mode,
    input  cell_in_t   ci,
    output logic       q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= cell_next(mode, ci);
    end
endmodule

// File: rtl/mmtr_reg.sv
module mmtr_reg
    import mmtr_pkg::*;
#(
    parameter int           W       = 4,
    parameter logic [W-1:0] FB_TAPS = 'b1001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_sel,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] state_q,
    output logic         ser_out
);
    localparam int LAST = W - 1;

    mmtr_mode_e   mode;
    logic         fb;
    logic         head;
    logic [W-1:0] link;

    assign mode = mmtr_mode_e'(mode_sel);

    mmtr_feedback #(.W(W), .TAPS(FB_TAPS)) u_fb (
        .state (state_q),
        .fb    (fb)
    );

    // Stage-0 source: serial input in shift mode, tap feedback otherwise.
    assign head = (mode == MODE_SHIFT) ? ser_in : fb;
    assign link = {state_q[LAST-1:0], head};

    for (genvar k = 0; k < W; k++) begin : g_cell
        cell_in_t ci;
        assign ci.link = link[k];
        assign ci.par  = par_in[k];
        mmtr_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .ci   (ci),
            .q    (state_q[k])
        );
    end

    assign ser_out = state_q[LAST];

    // R1: reset clears every stage
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_q == '0 && ser_out == 1'b0));

    // R2: shift moves serial data in at stage 0
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |=>
            state_q == {$past(state_q[LAST-1:0]), $past(ser_in)});

    // R3: clear mode empties the register
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |=> state_q == '0);

    // R4: load mode captures the parallel word
    a_r4_load_captures: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |=> state_q == $past(par_in));

    // R5: signature mode folds the word into the shifted state
    a_r5_sign_folds: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10) |=>
            state_q == ({$past(state_q[LAST-1:0]), ^($past(state_q) & FB_TAPS)}
                        ^ $past(par_in)));
endmodule

// File: tb/mmtr_reg_bench.sv
`timescale 1ns/1ps
module mmtr_reg_bench;
    localparam int           W    = 4;
    localparam logic [W-1:0] TAPS = 4'b1001;   // 1 + x + x^4, per R5
    localparam real          TCK  = 8.0;       // 125 MHz
    localparam int           PER  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'b01;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic [W-1:0] state_q;
    logic         ser_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(TCK/2) clk = ~clk;

    mmtr_reg #(.W(W), .FB_TAPS(TAPS)) u_mmtr_reg (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .par_in(par_in),
        .ser_in(ser_in), .state_q(state_q), .ser_out(ser_out)
    );

    function automatic logic [W-1:0] ref_sign(logic [W-1:0] q, logic [W-1:0] z);
        logic f;
        f = ^(q & TAPS);
        return {q[W-2:0], f} ^ z;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then move to the next falling edge.
    task automatic step(logic [1:0] m, logic [W-1:0] z, logic s);
        mode_sel = m; par_in = z; ser_in = s;
        @(negedge clk);
    endtask

    task automatic load(logic [W-1:0] v);
        step(2'b11, v, 1'b0);
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp;
        logic [W-1:0] gold;
        logic [PER:0] seen;

        // R1: reset
        par_in = 4'hF; ser_in = 1'b1; mode_sel = 2'b11;
        @(negedge clk); @(negedge clk);
        check("R1 reset state", state_q, '0);
        check("R1 reset ser_out", {{(W-1){1'b0}}, ser_out}, '0);
        rst = 1'b0;

        // R4: every load value, ser_in toggling with no effect
        for (int v = 0; v < (1 << W); v++) begin
            step(2'b11, W'(v), v[0]);
            check("R4 load", state_q, W'(v));
            check("R6 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, state_q[W-1]});
        end

        // R3: clear from several values with noisy inputs
        for (int v = 1; v < (1 << W); v += 5) begin
            load(W'(v));
            step(2'b01, 4'hF, 1'b1);
            check("R3 clear", state_q, '0);
        end

        // R2/R6: shift a bit pattern through
        load(4'hA);
        exp = 4'hA;
        for (int i = 0; i < 10; i++) begin
            logic b;
            b = ((i * 3 + 1) % 4) < 2;
            step(2'b00, 4'hF, b);
            exp = {exp[W-2:0], b};
            check("R2 shift", state_q, exp);
            check("R6 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, exp[W-1]});
        end

        // R5: every seed with a computed parallel word
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] z;
            z = W'((v * 11 + 5) % (1 << W));
            load(W'(v));
            step(2'b10, z, 1'b1);
            check("R5 signature step", state_q, ref_sign(W'(v), z));
        end

        // R7: full period from seed 1 with par_in at 0
        load(4'h1);
        seen = '0;
        seen[1] = 1'b1;
        exp = 4'h1;
        for (int i = 1; i <= PER; i++) begin
            step(2'b10, '0, 1'b0);
            exp = ref_sign(exp, '0);
            check("R7 sequence", state_q, exp);
            if (i < PER) begin
                n_run++;
                if (state_q == '0 || seen[state_q]) begin
                    n_fail++;
                    $display("FAIL R7 repeat: actual %h expected new state", state_q);
                end
                seen[state_q] = 1'b1;
            end
        end
        check("R7 period return", state_q, 4'h1);

        // R8: single-bit flips during a 12-word compaction
        step(2'b01, '0, 1'b0);
        gold = '0;
        for (int i = 0; i < 12; i++) begin
            logic [W-1:0] z;
            z = W'((i * 7 + 3) % (1 << W));
            step(2'b10, z, 1'b0);
            gold = ref_sign(gold, z);
        end
        check("R8 fault-free signature", state_q, gold);
        for (int j = 0; j < 12; j += 2) begin
            step(2'b01, '0, 1'b0);
            for (int i = 0; i < 12; i++) begin
                logic [W-1:0] z;
                z = W'((i * 7 + 3) % (1 << W));
                if (i == j) z[j % W] = ~z[j % W];
                step(2'b10, z, 1'b0);
            end
            n_run++;
            if (state_q == gold) begin
                n_fail++;
                $display("FAIL R8 flip at %0d: actual %h expected not %h", j, state_q, gold);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule